// File: doc/BRIEF.md
# Mixed-Access Control/Status Register

This block is a single addressable register word on a simple single-cycle register bus. Its bit positions are divided into fields that behave differently. A plain control field is held in flip-flops and drives the application logic directly. A notified control field is also held in flip-flops, and it emits a one-clock pulse to the application logic each time a bus write reaches the register. A status field has no storage of its own. A read returns the value that the application logic is driving onto it.

Firmware changes control settings with one write and reads control and status together with one read. The application logic sees each setting on a dedicated port, and it uses the pulse to react to a new setting even when the value has not changed. Field positions and widths are parameters. The default layout is control in bits [2:0], notified control in bits [4:3] and status in bits [7:5].

Top module: `typed_csr`

## Requirements
- R1: While reset is active, and until the internal synchronised reset releases, `ctl_o`, `wch_o`, `wch_wr_o` and `bus_rdata` are all 0.
- R2: A write (`bus_req`=1, `bus_we`=1) accepted at a clock edge updates `ctl_o` to `bus_wdata[2:0]` directly after that edge.
- R3: The same write updates `wch_o` to `bus_wdata[4:3]`. Cycles without a write leave `ctl_o` and `wch_o` unchanged.
- R4: `wch_wr_o` is high for exactly the one cycle after each accepted write. This holds even when the written value equals the stored value. Back-to-back writes keep it high for consecutive cycles.
- R5: `wch_wr_o` stays 0 after any cycle that is a read or has no request.
- R6: Bus writes to bits [7:5] are ignored: a later read returns the status input in those bits, not the written data.
- R7: A read (`bus_req`=1, `bus_we`=0) accepted at an edge places the following word on `bus_rdata` after that edge: bits [7:5] hold `sts_i` sampled at that edge, bits [4:3] hold the notified field and bits [2:0] hold the plain field.
- R8: `bus_rdata` holds its value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, one cycle after the read |
| sts_i | input | 3 | Status value from application logic |
| ctl_o | output | 3 | Plain control field value |
| wch_o | output | 2 | Notified control field value |
| wch_wr_o | output | 1 | One-cycle pulse after each register write |

## Verification
The bench builds the block with its default layout: three control bits at the bottom, two notified bits in the middle and three status bits at the top. With this layout every field sits next to another field of a different type, so a misplaced slice or shifted boundary corrupts a neighbour and shows up in the read word. Writes with all-ones data reach the ignored status bits. Repeated identical writes and back-to-back writes test the pulse in its hardest cases. Random mixes of reads, writes and idle cycles with varying status inputs cover the sampling instant and the hold behaviour of the read data.

// File: rtl/csr_pkg.sv
package csr_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_op_e;

  function automatic logic [31:0] fld_mask(input int lsb, input int w);
    return ((32'h1 << w) - 32'h1) << lsb;
  endfunction

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/csr_flop_field.sv
module csr_flop_field #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  AST_FIELD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wdata)); // R2
  AST_FIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R3

endmodule

// File: rtl/csr_watch_field.sv
module csr_watch_field #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         wr_pulse
);

  logic pulse_d;

  csr_flop_field #(.W(W)) u_val (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (wdata),
    .q     (q)
  );

  always_comb pulse_d = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_pulse <= 1'b0;
    else        wr_pulse <= pulse_d;
  end

  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_pulse); // R4
  AST_PULSE_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_pulse); // R5

endmodule

// File: rtl/csr_read_port.sv
module csr_read_port #(
  parameter int DW      = 8,
  parameter int CTL_LSB = 0,
  parameter int CTL_W   = 3,
  parameter int WCH_LSB = 3,
  parameter int WCH_W   = 2,
  parameter int STS_LSB = 5,
  parameter int STS_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [CTL_W-1:0] ctl,
  input  logic [WCH_W-1:0] wch,
  input  logic [STS_W-1:0] sts,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] word;
  logic [DW-1:0] rdata_d;

  always_comb begin
    word = '0;
    word[CTL_LSB +: CTL_W] = ctl;
    word[WCH_LSB +: WCH_W] = wch;
    word[STS_LSB +: STS_W] = sts;
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) rdata_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R8

endmodule

// File: rtl/typed_csr.sv
module typed_csr
  import csr_pkg::*;
#(
  parameter int DW         = 8,
  parameter int CTL_LSB    = 0,
  parameter int CTL_W      = 3,
  parameter int WCH_LSB    = 3,
  parameter int WCH_W      = 2,
  parameter int STS_LSB    = 5,
  parameter int STS_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [STS_W-1:0] sts_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic [WCH_W-1:0] wch_o,
  output logic             wch_wr_o
);

  localparam logic [31:0] WR_MASK32 = fld_mask(CTL_LSB, CTL_W) | fld_mask(WCH_LSB, WCH_W);
  localparam logic [DW-1:0] WR_MASK = WR_MASK32[DW-1:0];

  logic    rst_s_n;
  bus_op_e op;
  logic    wr_en;
  logic    rd_en;
  logic    unused_ro_wbits;

  csr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  always_comb begin
    op = BUS_IDLE;
    if (bus_req) op = bus_we ? BUS_WRITE : BUS_READ;
  end

  assign wr_en = (op == BUS_WRITE);
  assign rd_en = (op == BUS_READ);

  // Status bit positions take no part in a write.
  assign unused_ro_wbits = ^(bus_wdata & ~WR_MASK);

  csr_flop_field #(.W(CTL_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_s_n),
    .wr_en (wr_en),
    .wdata (bus_wdata[CTL_LSB +: CTL_W]),
    .q     (ctl_o)
  );

  csr_watch_field #(.W(WCH_W)) u_wch (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (wr_en),
    .wdata    (bus_wdata[WCH_LSB +: WCH_W]),
    .q        (wch_o),
    .wr_pulse (wch_wr_o)
  );

  csr_read_port #(
    .DW(DW), .CTL_LSB(CTL_LSB), .CTL_W(CTL_W),
    .WCH_LSB(WCH_LSB), .WCH_W(WCH_W), .STS_LSB(STS_LSB), .STS_W(STS_W)
  ) u_rd (
    .clk   (clk),
    .rst_n (rst_s_n),
    .rd_en (rd_en),
    .ctl   (ctl_o),
    .wch   (wch_o),
    .sts   (sts_i),
    .rdata (bus_rdata)
  );

  AST_RD_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_en |=> bus_rdata[STS_LSB +: STS_W] == $past(sts_i)); // R7
  AST_RD_CTL_FIELD: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_en |=> bus_rdata[CTL_LSB +: CTL_W] == $past(ctl_o)); // R7
  AST_PULSE_WITH_VALUE: assert property (@(posedge clk) disable iff (!rst_s_n)
    wch_wr_o |-> wch_o == $past(bus_wdata[WCH_LSB +: WCH_W])); // R4
  AST_IN_RESET_QUIET: assert property (@(posedge clk)
    !rst_s_n |-> (!wch_wr_o && ctl_o == '0 && wch_o == '0)); // R1

endmodule

// File: tb/typed_csr_tb.sv
module typed_csr_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_req, bus_we;
  logic [7:0] bus_wdata, bus_rdata;
  logic [2:0] sts_i, ctl_o;
  logic [1:0] wch_o;
  logic       wch_wr_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic [2:0] exp_ctl;
  logic [1:0] exp_wch;
  logic       exp_stb;
  logic [7:0] exp_rd;
  bit         prev_wr, prev_rd;

  always #10 clk = ~clk;

  typed_csr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_i(sts_i),
    .ctl_o(ctl_o), .wch_o(wch_o), .wch_wr_o(wch_wr_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_word(input logic [2:0] s, input logic [1:0] w, input logic [2:0] c);
    return {s, w, c};
  endfunction

  task automatic compare_all();
    check("R2 ctl_o", {5'd0, ctl_o}, {5'd0, exp_ctl});
    check("R3 wch_o", {6'd0, wch_o}, {6'd0, exp_wch});
    if (prev_wr) check("R4 wch_wr_o after write", {7'd0, wch_wr_o}, {7'd0, exp_stb});
    else         check("R5 wch_wr_o quiet", {7'd0, wch_wr_o}, {7'd0, exp_stb});
    if (prev_rd) check("R7 bus_rdata", bus_rdata, exp_rd);
    else         check("R8 bus_rdata hold", bus_rdata, exp_rd);
  endtask

  // Called at a falling edge: check, then drive one bus cycle.
  task automatic step(input logic req, input logic we, input logic [7:0] wd, input logic [2:0] st);
    compare_all();
    bus_req = req; bus_we = we; bus_wdata = wd; sts_i = st;
    prev_wr = req && we;
    prev_rd = req && !we;
    if (req && !we) exp_rd = rd_word(st, exp_wch, exp_ctl);
    if (req && we) begin
      exp_ctl = wd[2:0];
      exp_wch = wd[4:3];
    end
    exp_stb = req && we;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_req = 0; bus_we = 0; bus_wdata = 8'hA5; sts_i = 3'b111;
    exp_ctl = 0; exp_wch = 0; exp_stb = 0; exp_rd = 0; prev_wr = 0; prev_rd = 0;
    repeat (3) @(negedge clk);
    check("R1 ctl_o reset", {5'd0, ctl_o}, 8'd0);
    check("R1 wch_o reset", {6'd0, wch_o}, 8'd0);
    check("R1 wch_wr_o reset", {7'd0, wch_wr_o}, 8'd0);
    check("R1 bus_rdata reset", bus_rdata, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs after release", {ctl_o, wch_o, wch_wr_o, bus_rdata[1:0]}, 8'd0);

    // Directed corners
    step(1, 1, 8'hFF, 3'b000);        // write all ones: status bits must be dropped
    step(1, 0, 8'h00, 3'b000);        // read
    step(0, 0, 8'h00, 3'b010);
    check("R6 status bits not written", {5'd0, bus_rdata[7:5]}, 8'd0);
    step(1, 1, 8'h1F, 3'b000);        // same value again: pulse still fires (R4)
    step(1, 1, 8'h0A, 3'b000);        // back-to-back write
    step(1, 1, 8'h0A, 3'b000);
    step(0, 0, 8'h00, 3'b000);        // idle: pulse must drop (R5)
    step(1, 0, 8'h00, 3'b101);        // read with live status (R7)
    step(1, 0, 8'hFF, 3'b011);        // back-to-back read
    step(0, 1, 8'hFF, 3'b110);        // we without req: no write (R3/R8)
    step(1, 1, 8'hE0, 3'b001);        // write zeros to control, ones to status bits
    step(1, 0, 8'h00, 3'b000);
    step(0, 0, 8'h00, 3'b000);
    check("R6 status after E0 write", bus_rdata, 8'h00);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic r, w;
      r = ($urandom % 4) != 0;
      w = $urandom % 2;
      step(r, w, 8'($urandom), 3'($urandom));
    end
    step(0, 0, 8'h00, 3'b000);
    compare_all();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule